// File: doc/BRIEF.md
# SMBus Host Notify Receiver

On a system management bus, a peripheral can take the master role and send a short status message to the host, which then acts as a slave. This block sits on the host side and sits behind an I2C slave bit engine. The engine reports start conditions, stop conditions and each received byte as single-cycle events. The block parses these events into a notify message. A message has the shape of a word write: the host's own write address, then a byte that names the sender, then a 16-bit status word. The low byte of the word comes first and the high byte second.

For each byte the block accepts, it tells the bit engine to acknowledge it. When a well-formed message ends with stop, the block raises a one-cycle notification pulse. The sender's address and the status word are presented with the pulse and hold their values afterwards. A pending flag stays set until the consumer acknowledges the notification. A sticky overflow flag records that a message arrived while an earlier one was still pending. Messages for other addresses, read-direction messages, truncated messages, over-long messages and messages cut by a new start leave no trace.

Top module: `smbus_host_notify_rx`

## Requirements
- R1: After reset, `ack_o`, `note_valid`, `note_pending` and `note_overflow` are 0, and `note_addr` and `note_word` are all zeros.
- R2: The first byte after a start is accepted only if it equals `{HOST_ADDR, 1'b0}`, meaning the host address in bits 7:1 and the write bit (0) in bit 0. For any other value, including the read bit (1), that byte and every later byte up to the next start are not acknowledged and produce no notification.
- R3: Once the address byte has matched, the address byte and the next three bytes each raise `ack_o` for exactly one cycle, in the cycle after their `byte_vld` event.
- R4: In a completed message, `note_addr` is bits 7:1 of the first byte after the address. `note_word` is `{third byte, second byte}`, so the low byte is the one received first.
- R5: `note_valid` is a one-cycle pulse, raised in the cycle after a stop event that follows exactly three accepted bytes after the address. `note_addr` and `note_word` change only together with this pulse.
- R6: A stop that comes after fewer than three bytes following the address produces no pulse and leaves `note_addr` and `note_word` unchanged.
- R7: A fourth byte after the address is not acknowledged, and the message is dropped at its stop.
- R8: A start event in the middle of a message discards what has been captured so far. The bytes that follow are parsed as a fresh message.
- R9: `note_pending` is set together with `note_valid` and is cleared in the cycle after a `note_ack` event that has no completion in the same cycle.
- R10: If a message completes while `note_pending` is set and no `note_ack` arrives in the same cycle, `note_overflow` is set. Once set, it stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_start | input | 1 | Start or repeated start seen by the bit engine (one cycle) |
| ev_stop | input | 1 | Stop seen by the bit engine (one cycle) |
| byte_vld | input | 1 | A received byte is present on `byte_dat` (one cycle) |
| byte_dat | input | 8 | Received byte, most significant bit first on the wire |
| ack_o | output | 1 | Acknowledge the byte reported in the previous cycle |
| note_ack | input | 1 | Consumer has taken the pending notification |
| note_valid | output | 1 | One-cycle notification pulse |
| note_addr | output | 7 | Address of the notifying device |
| note_word | output | 16 | Status word from the notifying device |
| note_pending | output | 1 | Notification not yet acknowledged |
| note_overflow | output | 1 | Sticky: a notification was overwritten before it was acknowledged |

## Verification
The assertions check local properties on every cycle:
- each acknowledge follows a byte event;
- no acknowledge is given in the skip state or the full state;
- each pulse follows a stop and is accompanied by pending;
- the captured outputs hold between pulses;
- an acknowledge clears pending;
- the overflow flag stays set.

Only the bench's scenarios can show the message-level properties. These are the byte-to-field mapping of the sender address and word, the rejection of foreign and read addresses, and the dropping of short, long and restarted messages. The bench also shows the exact cycle of each pulse against a scoreboard of expected notifications.

// File: rtl/smbhn_pkg.sv
package smbhn_pkg;

    localparam int ADDR_W      = 7;
    localparam int BYTE_W      = 8;
    localparam int WORD_BYTES  = 2;
    localparam int WORD_W      = BYTE_W * WORD_BYTES;
    // bytes after the address: sender id plus the word
    localparam int BODY_BYTES  = 1 + WORD_BYTES;
    localparam int IDX_W       = $clog2(BODY_BYTES + 1);

    typedef enum logic [2:0] {
        ST_IDLE,   // between messages
        ST_ADDR,   // waiting for the address byte
        ST_BODY,   // collecting body bytes
        ST_FULL,   // body complete, waiting for stop
        ST_SKIP    // not ours or malformed, ignore until next start
    } frame_st_t;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [WORD_W-1:0] word;
    } note_t;

    function automatic logic [BYTE_W-1:0] wr_addr_byte(input logic [ADDR_W-1:0] a);
        return {a, 1'b0};
    endfunction

endpackage

// File: rtl/smbhn_frame_fsm.sv
module smbhn_frame_fsm
    import smbhn_pkg::*;
#(
    parameter logic [ADDR_W-1:0] HOST_ADDR = 7'h08
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ev_start,
    input  logic              ev_stop,
    input  logic              byte_vld,
    input  logic [BYTE_W-1:0] byte_dat,
    output logic              ack_o,
    output logic              store_en,
    output logic [IDX_W-1:0]  store_idx,
    output logic              commit
);

    frame_st_t        st_q, st_d;
    logic [IDX_W-1:0] idx_q, idx_d;
    logic             ack_d;

    always_comb begin
        st_d      = st_q;
        idx_d     = idx_q;
        ack_d     = 1'b0;
        store_en  = 1'b0;
        store_idx = idx_q;
        commit    = 1'b0;
        if (ev_start) begin
            st_d  = ST_ADDR;
            idx_d = '0;
        end else if (ev_stop) begin
            commit = (st_q == ST_FULL);
            st_d   = ST_IDLE;
            idx_d  = '0;
        end else if (byte_vld) begin
            unique case (st_q)
                ST_ADDR: begin
                    if (byte_dat == wr_addr_byte(HOST_ADDR)) begin
                        st_d  = ST_BODY;
                        ack_d = 1'b1;
                    end else begin
                        st_d  = ST_SKIP;
                    end
                end
                ST_BODY: begin
                    ack_d    = 1'b1;
                    store_en = 1'b1;
                    if (idx_q == IDX_W'(BODY_BYTES - 1)) begin
                        st_d = ST_FULL;
                    end else begin
                        idx_d = idx_q + 1'b1;
                    end
                end
                ST_FULL: st_d = ST_SKIP;
                default: st_d = st_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= ST_IDLE;
            idx_q <= '0;
            ack_o <= 1'b0;
        end else begin
            st_q  <= st_d;
            idx_q <= idx_d;
            ack_o <= ack_d;
        end
    end

    // R3: an acknowledge only ever answers a byte event
    a_r3_ack_follows_byte: assert property (@(posedge clk) disable iff (rst)
        ack_o |-> $past(byte_vld));

    // R2: bytes of a foreign or read message are never acknowledged
    a_r2_skip_silent: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_SKIP && byte_vld && !ev_start && !ev_stop) |=> !ack_o);

    // R7: a byte beyond the body is refused
    a_r7_no_ack_when_full: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_FULL && byte_vld && !ev_start && !ev_stop) |=> !ack_o);

endmodule

// File: rtl/smbhn_capture.sv
module smbhn_capture
    import smbhn_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              store_en,
    input  logic [IDX_W-1:0]  store_idx,
    input  logic [BYTE_W-1:0] byte_dat,
    output note_t             staged
);

    logic [BYTE_W-1:0] slot_q [BODY_BYTES];

    for (genvar i = 0; i < BODY_BYTES; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                slot_q[i] <= '0;
            end else if (store_en && store_idx == IDX_W'(i)) begin
                slot_q[i] <= byte_dat;
            end
        end
    end

    // sender address sits in bits 7:1 of the first body byte
    assign staged.addr = slot_q[0][BYTE_W-1:1];

    // word bytes arrive low first
    for (genvar k = 0; k < WORD_BYTES; k++) begin : g_word
        assign staged.word[k*BYTE_W +: BYTE_W] = slot_q[k+1];
    end

endmodule

// File: rtl/smbhn_notify_out.sv
module smbhn_notify_out
    import smbhn_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              commit,
    input  note_t             staged,
    input  logic              note_ack,
    output logic              note_valid,
    output logic [ADDR_W-1:0] note_addr,
    output logic [WORD_W-1:0] note_word,
    output logic              note_pending,
    output logic              note_overflow
);

    note_t held_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            held_q        <= '0;
            note_valid    <= 1'b0;
            note_pending  <= 1'b0;
            note_overflow <= 1'b0;
        end else begin
            note_valid <= commit;
            if (commit) begin
                held_q       <= staged;
                note_pending <= 1'b1;
                if (note_pending && !note_ack) begin
                    note_overflow <= 1'b1;
                end
            end else if (note_ack) begin
                note_pending <= 1'b0;
            end
        end
    end

    assign note_addr = held_q.addr;
    assign note_word = held_q.word;

    // R9: a pulse always comes with pending set
    a_r9_valid_sets_pending: assert property (@(posedge clk) disable iff (rst)
        note_valid |-> note_pending);

    // R9: acknowledge without a new completion clears pending
    a_r9_ack_clears: assert property (@(posedge clk) disable iff (rst)
        (note_ack && !commit) |=> !note_pending);

    // R10: overflow is sticky
    a_r10_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
        note_overflow |=> note_overflow);

    // R5: captured outputs move only with the pulse
    a_r5_hold_between: assert property (@(posedge clk) disable iff (rst)
        !note_valid |-> ($stable(note_addr) && $stable(note_word)));

endmodule

// File: rtl/smbus_host_notify_rx.sv
module smbus_host_notify_rx
    import smbhn_pkg::*;
#(
    parameter logic [ADDR_W-1:0] HOST_ADDR = 7'h08
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ev_start,
    input  logic              ev_stop,
    input  logic              byte_vld,
    input  logic [BYTE_W-1:0] byte_dat,
    output logic              ack_o,
    input  logic              note_ack,
    output logic              note_valid,
    output logic [ADDR_W-1:0] note_addr,
    output logic [WORD_W-1:0] note_word,
    output logic              note_pending,
    output logic              note_overflow
);

    logic             store_en;
    logic [IDX_W-1:0] store_idx;
    logic             commit;
    note_t            staged;

    smbhn_frame_fsm #(.HOST_ADDR(HOST_ADDR)) fsm_i (
        .clk      (clk),
        .rst      (rst),
        .ev_start (ev_start),
        .ev_stop  (ev_stop),
        .byte_vld (byte_vld),
        .byte_dat (byte_dat),
        .ack_o    (ack_o),
        .store_en (store_en),
        .store_idx(store_idx),
        .commit   (commit)
    );

    smbhn_capture cap_i (
        .clk      (clk),
        .rst      (rst),
        .store_en (store_en),
        .store_idx(store_idx),
        .byte_dat (byte_dat),
        .staged   (staged)
    );

    smbhn_notify_out out_i (
        .clk          (clk),
        .rst          (rst),
        .commit       (commit),
        .staged       (staged),
        .note_ack     (note_ack),
        .note_valid   (note_valid),
        .note_addr    (note_addr),
        .note_word    (note_word),
        .note_pending (note_pending),
        .note_overflow(note_overflow)
    );

    // R5: every pulse answers a stop in the previous cycle
    a_r5_valid_after_stop: assert property (@(posedge clk) disable iff (rst)
        note_valid |-> $past(ev_stop));

endmodule

// File: tb/smbus_host_notify_rx_tb_top.sv
module smbus_host_notify_rx_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam logic [6:0] HOST = 7'h08;
    localparam logic [7:0] HOST_WR = {HOST, 1'b0};

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ev_start = 1'b0, ev_stop = 1'b0, byte_vld = 1'b0, note_ack = 1'b0;
    logic [7:0]  byte_dat = '0;
    logic        ack_o, note_valid, note_pending, note_overflow;
    logic [6:0]  note_addr;
    logic [15:0] note_word;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        logic [6:0]  a;
        logic [15:0] w;
    } exp_t;
    exp_t sb[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    smbus_host_notify_rx #(.HOST_ADDR(HOST)) dut_i (
        .clk(clk), .rst(rst), .ev_start(ev_start), .ev_stop(ev_stop),
        .byte_vld(byte_vld), .byte_dat(byte_dat), .ack_o(ack_o),
        .note_ack(note_ack), .note_valid(note_valid), .note_addr(note_addr),
        .note_word(note_word), .note_pending(note_pending),
        .note_overflow(note_overflow)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic evt(input bit s, input bit p, input bit v, input logic [7:0] b);
        @(negedge clk);
        ev_start = s; ev_stop = p; byte_vld = v; byte_dat = b;
        @(negedge clk);
        ev_start = 0; ev_stop = 0; byte_vld = 0;
    endtask

    task automatic send_byte(input logic [7:0] b, input bit exp_ack, input string req);
        evt(0, 0, 1, b);
        check(ack_o == exp_ack, req, ack_o, exp_ack);
    endtask

    task automatic full_msg(input logic [6:0] dev, input logic [15:0] w);
        evt(1, 0, 0, 0);
        send_byte(HOST_WR, 1, "R3");
        send_byte({dev, 1'b0}, 1, "R3");
        send_byte(w[7:0], 1, "R3");
        send_byte(w[15:8], 1, "R3");
        sb.push_back('{a: dev, w: w});
        evt(0, 1, 0, 0);
    endtask

    task automatic ack_note();
        @(negedge clk); note_ack = 1;
        @(negedge clk); note_ack = 0;
    endtask

    // monitor: pops the scoreboard on every pulse
    always @(negedge clk) begin
        if (!rst && note_valid) begin
            if (sb.size() == 0) begin
                check(0, "R6 or R7 spurious pulse", {note_addr, note_word}, 0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check(note_addr == e.a, "R4 addr", note_addr, e.a);
                check(note_word == e.w, "R4 word", note_word, e.w);
                check(note_pending, "R9 pending with pulse", note_pending, 1);
            end
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk); rst = 0;
        // R1
        check(!ack_o && !note_valid && !note_pending && !note_overflow, "R1 flags",
              {ack_o, note_valid, note_pending, note_overflow}, 0);
        check(note_addr == 0 && note_word == 0, "R1 data", {note_addr, note_word}, 0);

        // good message (R2, R3, R4, R5)
        full_msg(7'h1A, 16'hABCD);
        @(negedge clk);
        check(!note_valid, "R5 single pulse", note_valid, 0);
        check(note_pending, "R9 pending held", note_pending, 1);
        ack_note();
        check(!note_pending, "R9 cleared by ack", note_pending, 0);

        // foreign address (R2)
        evt(1, 0, 0, 0);
        send_byte(8'h22, 0, "R2 foreign addr");
        send_byte(8'h34, 0, "R2 later byte");
        send_byte(8'h01, 0, "R2 later byte");
        send_byte(8'h02, 0, "R2 later byte");
        evt(0, 1, 0, 0);
        // read direction (R2)
        evt(1, 0, 0, 0);
        send_byte({HOST, 1'b1}, 0, "R2 read bit");
        send_byte(8'h40, 0, "R2 read later byte");
        evt(0, 1, 0, 0);
        @(negedge clk);
        check(note_word == 16'hABCD, "R2 outputs kept", note_word, 16'hABCD);

        // short message (R6)
        evt(1, 0, 0, 0);
        send_byte(HOST_WR, 1, "R6 addr");
        send_byte(8'h40, 1, "R6 dev");
        send_byte(8'h01, 1, "R6 low");
        evt(0, 1, 0, 0);
        @(negedge clk);
        check(note_word == 16'hABCD && note_addr == 7'h1A, "R6 outputs kept",
              {note_addr, note_word}, {7'h1A, 16'hABCD});
        check(!note_pending, "R6 no pending", note_pending, 0);

        // over-long message (R7)
        evt(1, 0, 0, 0);
        send_byte(HOST_WR, 1, "R7 addr");
        send_byte(8'h50, 1, "R7 dev");
        send_byte(8'h11, 1, "R7 low");
        send_byte(8'h22, 1, "R7 high");
        send_byte(8'h33, 0, "R7 extra byte refused");
        evt(0, 1, 0, 0);
        @(negedge clk);
        check(!note_pending, "R7 dropped", note_pending, 0);

        // restart mid-message (R8)
        evt(1, 0, 0, 0);
        send_byte(HOST_WR, 1, "R8 addr");
        send_byte(8'h60, 1, "R8 dev");
        send_byte(8'h77, 1, "R8 low");
        full_msg(7'h31, 16'h0605);
        @(negedge clk);
        check(!note_overflow, "R10 no overflow yet", note_overflow, 0);

        // completion while pending (R10)
        full_msg(7'h44, 16'h1234);
        @(negedge clk);
        check(note_overflow, "R10 overflow set", note_overflow, 1);
        ack_note();
        check(!note_pending, "R9 ack clears", note_pending, 0);
        full_msg(7'h05, 16'hFFEE);
        @(negedge clk);
        check(note_overflow, "R10 still sticky", note_overflow, 1);
        ack_note();

        repeat (3) @(negedge clk);
        check(sb.size() == 0, "R5 all pulses seen", sb.size(), 0);

        // reset clears overflow (R1)
        rst = 1;
        repeat (2) @(negedge clk);
        rst = 0;
        @(negedge clk);
        check(!note_overflow && !note_pending && note_word == 0, "R1 after reset",
              {note_overflow, note_pending, note_word}, 0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule